// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings a display controller from deep standby to an active, displaying state, and later puts it back to sleep. It works by issuing a fixed list of register writes to a 9-bit command/data serializer. The list lives in a table inside the block. Each write goes out as one or more 9-bit words. Bit 8 of a word marks it as a data byte (1) or a command byte (0). A flag marks the last word of a transfer.

A one-cycle `enReq` pulse starts power-up and a one-cycle `disReq` pulse starts power-down. The block issues one word at a time and waits for the serializer's completion pulse before it sends the next word. `enabled` shows the panel's current state and `seqError` reports how the last sequence ended.

Power-up opens with three bare zero commands, each followed by a timed pause of at least `CYC_PER_MS*WAIT_MS` clock cycles. A failure during these three commands stops the sequence at once. During the rest of power-up, failures are only recorded, and the sequence still runs to its end.

Top module: `panel_power_seq`

## Requirements
- R1: Power-up starts with three transfers, each a single command word 0x000 with `reqLast`=1. After the serializer reports each of them done, the next request comes at least `CYC_PER_MS*WAIT_MS` cycles later.
- R2: After the three zero commands, power-up sends these words in this order: command 0xB0 with data 0x17; command 0xBC with data 0x80; command 0x3B with data 0x00; command 0xB0 with data 0x16; command 0xB8 with data 0xFF and 0xF9; bare command 0x11; command 0xBD with data 0x04; bare command 0x29. A word with bit 8 set is data and one with bit 8 clear is a command. `reqLast` is high on the final word of each transfer.
- R3: A failure reported on any of the three zero commands ends power-up at once. No further request is issued, `seqError` becomes 1 and `enabled` stays 0.
- R4: A failure reported on a word after the zero commands does not stop power-up. All remaining words are still sent, and at the end `seqError`=1 and `enabled`=0.
- R5: `enabled` becomes 1 only when power-up ends with no failure. `seqError` is cleared when any sequence starts.
- R6: Power-down sends bare command 0x28; command 0xB8 with data 0x80 and 0x02; bare command 0x10; command 0xB0 with data 0x00. At its end `enabled`=0, and `seqError` is 1 exactly when a failure was reported during it.
- R7: `enReq` while enabled, and `disReq` while not enabled, issue no request and leave `busy` low.
- R8: `reqValid` is a single-cycle pulse, and no new request is issued until the serializer has reported the previous one done.
- R9: `enReq` and `disReq` arriving while a sequence is running are ignored, and the running sequence is not changed.
- R10: After reset, `busy`, `enabled`, `seqError` and `reqValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| enReq | input | 1 | power-up request pulse |
| disReq | input | 1 | power-down request pulse |
| reqValid | output | 1 | one-cycle request to the serializer |
| reqWord | output | 9 | word to send; bit 8 = data(1)/command(0) |
| reqLast | output | 1 | word ends its transfer |
| spiDone | input | 1 | serializer finished the outstanding word |
| spiFail | input | 1 | qualifies spiDone as a failed transfer |
| busy | output | 1 | a sequence is running |
| enabled | output | 1 | panel is powered up |
| seqError | output | 1 | last sequence saw a failure |

## Verification
The bench injects failures in two places. One is on the second zero command: a design that ignored it would keep sending words, or would report the panel enabled. The other is on a word in the middle of power-up: a design that aborted there would stop short of the expected word list, and one that dropped the failure would set `enabled`. The bench measures the gap after each zero command, which catches a pause that is missing or too short. It also sends repeated and conflicting requests, both while a sequence runs and while the panel is already in the requested state. A sequencer that accepted those requests would emit words that no sequence expects, or would restart partway through.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;
  localparam int IDX_W      = 5;
  localparam int UP_START   = 0;
  localparam int PRE_LEN    = 3;
  localparam int DOWN_START = 18;

  typedef struct packed {
    logic       pause;   // timed pause after completion
    logic       endSeq;  // final word of the sequence
    logic       last;    // final word of a transfer
    logic       isData;  // word type flag (bit 8 of the word)
    logic [7:0] val;
  } stepT;

  typedef struct packed {
    logic loadUp;
    logic loadDown;
    logic idxInc;
    logic waitLoad;
    logic waitDec;
    logic failSeen;
    logic finish;
    logic abort;
  } strobeT;

  function automatic stepT mk(input logic p, input logic e, input logic l,
                              input logic d, input logic [7:0] v);
    stepT s;
    s.pause = p; s.endSeq = e; s.last = l; s.isData = d; s.val = v;
    return s;
  endfunction

  // step table: zero commands, power-up body, power-down
  function automatic stepT stepAt(input logic [IDX_W-1:0] i);
    stepT s;
    case (int'(i))
      0, 1, 2: s = mk(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
      3:  s = mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB0);
      4:  s = mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h17);
      5:  s = mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hBC);
      6:  s = mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h80);
      7:  s = mk(1'b0, 1'b0, 1'b0, 1'b0, 8'h3B);
      8:  s = mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      9:  s = mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB0);
      10: s = mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h16);
      11: s = mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB8);
      12: s = mk(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF);
      13: s = mk(1'b0, 1'b0, 1'b1, 1'b1, 8'hF9);
      14: s = mk(1'b0, 1'b0, 1'b1, 1'b0, 8'h11);
      15: s = mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hBD);
      16: s = mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h04);
      17: s = mk(1'b0, 1'b1, 1'b1, 1'b0, 8'h29);
      18: s = mk(1'b0, 1'b0, 1'b1, 1'b0, 8'h28);
      19: s = mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB8);
      20: s = mk(1'b0, 1'b0, 1'b0, 1'b1, 8'h80);
      21: s = mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h02);
      22: s = mk(1'b0, 1'b0, 1'b1, 1'b0, 8'h10);
      23: s = mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB0);
      24: s = mk(1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
      default: s = mk(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import panel_seq_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int WAIT_MS    = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  strobeT strb,
  output stepT   step,
  output logic   waitZero,
  output logic   inPreamble,
  output logic   enabled,
  output logic   seqError
);
  localparam int WAIT_CYC = CYC_PER_MS * WAIT_MS;
  localparam int CW       = $clog2(WAIT_CYC + 1);

  logic [IDX_W-1:0] idx;
  logic [CW-1:0]    waitCnt;
  logic             upMode;
  logic             errAcc;
  logic             errNow;

  assign step       = stepAt(idx);
  assign waitZero   = (waitCnt == '0);
  assign inPreamble = upMode && (idx < IDX_W'(PRE_LEN));
  assign errNow     = errAcc | strb.failSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      waitCnt  <= '0;
      upMode   <= 1'b0;
      errAcc   <= 1'b0;
      enabled  <= 1'b0;
      seqError <= 1'b0;
    end else begin
      if (strb.loadUp || strb.loadDown) begin
        idx      <= strb.loadUp ? IDX_W'(UP_START) : IDX_W'(DOWN_START);
        upMode   <= strb.loadUp;
        errAcc   <= 1'b0;
        seqError <= 1'b0;
      end else if (strb.idxInc) begin
        idx <= idx + IDX_W'(1);
      end
      if (strb.failSeen) errAcc <= 1'b1;
      if (strb.waitLoad)     waitCnt <= CW'(WAIT_CYC - 1);
      else if (strb.waitDec) waitCnt <= waitCnt - CW'(1);
      if (strb.finish) begin
        seqError <= errNow;
        enabled  <= upMode && !errNow;
      end
      if (strb.abort) begin
        seqError <= 1'b1;
        enabled  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seq_control.sv
module seq_control
  import panel_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enReq,
  input  logic   disReq,
  input  logic   enabled,
  input  stepT   step,
  input  logic   waitZero,
  input  logic   inPreamble,
  input  logic   spiDone,
  input  logic   spiFail,
  output strobeT strb,
  output logic   reqValid,
  output logic   busy
);
  typedef enum logic [1:0] {IDLE, ISSUE, WAITDONE, PAUSE} stateT;
  stateT state, nextState;

  assign reqValid = (state == ISSUE);
  assign busy     = (state != IDLE);

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      IDLE: begin
        if (enReq && !enabled) begin
          strb.loadUp = 1'b1;
          nextState   = ISSUE;
        end else if (disReq && enabled) begin
          strb.loadDown = 1'b1;
          nextState     = ISSUE;
        end
      end
      ISSUE: nextState = WAITDONE;
      WAITDONE: begin
        if (spiDone) begin
          if (spiFail && inPreamble) begin
            strb.abort = 1'b1;
            nextState  = IDLE;
          end else begin
            strb.failSeen = spiFail;
            if (step.pause) begin
              strb.waitLoad = 1'b1;
              nextState     = PAUSE;
            end else if (step.endSeq) begin
              strb.finish = 1'b1;
              nextState   = IDLE;
            end else begin
              strb.idxInc = 1'b1;
              nextState   = ISSUE;
            end
          end
        end
      end
      PAUSE: begin
        if (waitZero) begin
          strb.idxInc = 1'b1;
          nextState   = ISSUE;
        end else begin
          strb.waitDec = 1'b1;
        end
      end
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= IDLE;
    else        state <= nextState;
  end
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import panel_seq_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int WAIT_MS    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enReq,
  input  logic       disReq,
  output logic       reqValid,
  output logic [8:0] reqWord,
  output logic       reqLast,
  input  logic       spiDone,
  input  logic       spiFail,
  output logic       busy,
  output logic       enabled,
  output logic       seqError
);
  strobeT strb;
  stepT   step;
  logic   waitZero;
  logic   inPreamble;

  assign reqWord = {step.isData, step.val};
  assign reqLast = step.last;

  seq_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .enReq(enReq), .disReq(disReq),
    .enabled(enabled), .step(step), .waitZero(waitZero),
    .inPreamble(inPreamble), .spiDone(spiDone), .spiFail(spiFail),
    .strb(strb), .reqValid(reqValid), .busy(busy)
  );

  seq_datapath #(.CYC_PER_MS(CYC_PER_MS), .WAIT_MS(WAIT_MS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .step(step),
    .waitZero(waitZero), .inPreamble(inPreamble),
    .enabled(enabled), .seqError(seqError)
  );
endmodule

// File: rtl/panel_power_seq_chk.sv
module panel_power_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic enReq,
  input logic disReq,
  input logic reqValid,
  input logic spiDone,
  input logic busy,
  input logic enabled,
  input logic seqError
);
  logic outstanding;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        outstanding <= 1'b0;
    else if (reqValid) outstanding <= 1'b1;
    else if (spiDone)  outstanding <= 1'b0;
  end

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> !reqValid);
  assert_one_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> !outstanding);
  assert_ignore_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && enabled && enReq && !disReq) |=> !busy);
  assert_ignore_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enabled && disReq && !enReq) |=> !busy);
  assert_en_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled != $past(enabled)) |-> $fell(busy));
  assert_err_not_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seqError) |-> !enabled);
endmodule

bind panel_power_seq panel_power_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enReq(enReq), .disReq(disReq),
  .reqValid(reqValid), .spiDone(spiDone), .busy(busy),
  .enabled(enabled), .seqError(seqError)
);

// File: tb/tb_panel_power_seq.sv
module tb_panel_power_seq;
  localparam int CPM  = 10;
  localparam int WMS  = 2;
  localparam int WAIT = CPM * WMS;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enReq = 1'b0, disReq = 1'b0;
  logic reqValid, reqLast, busy, enabled, seqError;
  logic [8:0] reqWord;
  logic spiDone = 1'b0, spiFail = 1'b0;

  always #10 clk = ~clk;

  panel_power_seq #(.CYC_PER_MS(CPM), .WAIT_MS(WMS)) dut (
    .clk(clk), .rst_n(rst_n), .enReq(enReq), .disReq(disReq),
    .reqValid(reqValid), .reqWord(reqWord), .reqLast(reqLast),
    .spiDone(spiDone), .spiFail(spiFail), .busy(busy),
    .enabled(enabled), .seqError(seqError)
  );

  // item: [10]=pause follows, [9]=last, [8:0]=word
  logic [10:0] upList [18] = '{11'h600, 11'h600, 11'h600,
    11'h0B0, 11'h317, 11'h0BC, 11'h380, 11'h03B, 11'h300, 11'h0B0, 11'h316,
    11'h0B8, 11'h1FF, 11'h3F9, 11'h211, 11'h0BD, 11'h304, 11'h229};
  logic [10:0] downList [7] = '{11'h228, 11'h0B8, 11'h180, 11'h302,
    11'h210, 11'h0B0, 11'h300};

  logic [10:0] expQ [$];
  int total = 0, bad = 0;
  int failAt = -1, reqCount = 0, negCount = 0, doneStamp = 0;
  bit gapPending = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    negCount++;
  endtask

  // monitor / serializer model: pops expected items and compares
  initial begin
    logic [10:0] item;
    forever begin
      tick();
      if (spiDone) begin spiDone = 1'b0; spiFail = 1'b0; end
      if (reqValid) begin
        if (gapPending) begin
          chk(negCount - doneStamp >= WAIT, "R1", "pause after zero command",
              negCount - doneStamp, WAIT);
          gapPending = 0;
        end
        if (expQ.size() == 0) begin
          chk(0, "R2", "unexpected request word", int'(reqWord), 0);
          item = 11'h000;
        end else begin
          item = expQ.pop_front();
          chk({reqLast, reqWord} == item[9:0], "R2", "request word/last",
              int'({reqLast, reqWord}), int'(item[9:0]));
        end
        tick();
        chk(!reqValid, "R8", "request held for one cycle", int'(reqValid), 0);
        repeat (LAT - 1) tick();
        chk(!reqValid, "R8", "no request while outstanding", int'(reqValid), 0);
        spiDone = 1'b1;
        spiFail = (reqCount == failAt);
        gapPending = item[10] && !spiFail;
        doneStamp = negCount;
        reqCount++;
      end
    end
  end

  task automatic pulse(input bit up);
    @(negedge clk);
    if (up) enReq = 1'b1; else disReq = 1'b1;
    @(negedge clk);
    enReq = 1'b0; disReq = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic runSeq(input bit up, input int nExp, input int failIdx,
                        input bit poke, input string req);
    for (int i = 0; i < nExp; i++) expQ.push_back(up ? upList[i] : downList[i]);
    failAt = failIdx;
    reqCount = 0;
    gapPending = 0;
    pulse(up);
    chk(busy && !seqError, "R5", "busy and error cleared at start",
        int'({busy, seqError}), 2);
    if (poke) begin
      repeat (5) @(negedge clk);
      enReq = 1'b1; disReq = 1'b1;   // R9: ignored mid-sequence
      @(negedge clk);
      enReq = 1'b0; disReq = 1'b0;
    end
    waitIdle();
    chk(expQ.size() == 0, req, "all expected words sent", expQ.size(), 0);
    chk(reqCount == nExp, req, "request count", reqCount, nExp);
    expQ.delete();
  endtask

  task automatic ignored(input bit up, input string req);
    int starts = reqCount;
    bit sawBusy = 0;
    @(negedge clk);
    if (up) enReq = 1'b1; else disReq = 1'b1;
    @(negedge clk);
    enReq = 1'b0; disReq = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (busy) sawBusy = 1;
      @(negedge clk);
    end
    chk(!sawBusy && reqCount == starts, req, "request ignored",
        int'(sawBusy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "WATCHDOG", "run did not finish", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, enabled, seqError, reqValid} == 4'b0, "R10", "reset state",
        int'({busy, enabled, seqError, reqValid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, enabled, seqError, reqValid} == 4'b0, "R10", "idle after reset",
        int'({busy, enabled, seqError, reqValid}), 0);

    // R1 R2 R5 R9: clean power-up, poked mid-run
    runSeq(1'b1, 18, -1, 1'b1, "R9");
    chk(enabled && !seqError, "R5", "enabled after clean power-up",
        int'({enabled, seqError}), 2);

    ignored(1'b1, "R7");   // enable while enabled
    chk(enabled, "R7", "still enabled", int'(enabled), 1);

    // R6 clean power-down
    runSeq(1'b0, 7, -1, 1'b0, "R6");
    chk(!enabled && !seqError, "R6", "disabled after power-down",
        int'({enabled, seqError}), 0);

    ignored(1'b0, "R7");   // disable while disabled

    // R3 failure on second zero command
    runSeq(1'b1, 2, 1, 1'b0, "R3");
    chk(!enabled && seqError, "R3", "abort flags", int'({enabled, seqError}), 1);

    // R4 failure in body
    runSeq(1'b1, 18, 6, 1'b0, "R4");
    chk(!enabled && seqError, "R4", "accumulated error", int'({enabled, seqError}), 1);

    // R5 error cleared by a new clean sequence
    runSeq(1'b1, 18, -1, 1'b0, "R5");
    chk(enabled && !seqError, "R5", "clean power-up after error",
        int'({enabled, seqError}), 2);

    // R6 failure during power-down
    runSeq(1'b0, 7, 2, 1'b0, "R6");
    chk(!enabled && seqError, "R6", "power-down error", int'({enabled, seqError}), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule